// File: doc/BRIEF.md
# I2C Mode and Status Controller

This block tracks the role of an I2C bus interface and keeps its status byte up to date. It holds a master bit and a transmit bit, which together give the four roles: slave receive, slave transmit, master receive and master transmit. It watches strobes from the bus condition detectors and the byte engine, and it updates the status flags from them: bus busy, pending interrupt, arbitration lost, slave address match, general call and the last received bit.

The block also guards START generation. When the CPU asks for a START while in master mode, the block either sends one-cycle enables to the START generator and the bit counter reset, or it suppresses the request. It suppresses it when another master already holds the bus, or starts it in the same cycle. A suppressed request also drops the block out of master mode, which removes SCL drive.

Outside this request, the block leaves master mode on its own in three cases: after a STOP, at the end of a byte in which arbitration was lost, and on a suppressed START. The shift engine, baud-rate timing and pin filtering live elsewhere.

Top module: `i2c_role_tracker`

## Requirements
- R1: Status byte layout. Bit 7 is master and bit 6 is transmit, so bits 7:6 read 00 = slave receive, 01 = slave transmit, 10 = master receive, 11 = master transmit. Bit 5 is bus busy, bit 4 is the active-low pending flag, bit 3 the last received bit, bit 2 general call, bit 1 address match and bit 0 arbitration lost. After a synchronous reset the status reads 8'h10, irq_n is 1 and gen_start, cnt_rst and scl_drive are 0. Every update is visible one clock after the edge that samples its cause.
- R2: A `mode_wr` strobe loads bit 7 from `mode_mst` and bit 6 from `mode_tx`, unless an automatic drop (R3, R4, R6) occurs in the same cycle; the drop wins.
- R3: A detected STOP clears bits 7 and 6.
- R4: A `byte_done` while the arbitration-lost flag is set, or coincident with an `arb_lost` strobe, clears bits 7 and 6. An `arb_lost` strobe alone leaves the mode unchanged.
- R5: A `start_req` in master mode, with the bus free and no `start_det` in the same cycle, gives exactly one cycle of `gen_start` and `cnt_rst`.
- R6: A `start_req` in master mode while the bus is busy, or together with `start_det`, produces no `gen_start` and no `cnt_rst`, and clears bits 7 and 6.
- R7: A `start_req` in slave mode produces no pulse and leaves the mode unchanged.
- R8: Bus busy sets on `start_det` and clears on `stop_det`. If both arrive in the same cycle, `start_det` wins.
- R9: The pending flag (bit 4, mirrored on `irq_n`) goes to 0 on `byte_done`. It returns to 1 on `data_wr` or `irq_ack`. If `byte_done` arrives in the same cycle as either, `byte_done` wins.
- R10: The arbitration-lost flag sets on `arb_lost` and clears on `start_det`. The address-match and general-call flags set on their strobes and clear on `start_det` or `stop_det`. The last-received-bit flag takes `rx_bit` on `byte_done`.
- R11: `scl_drive` is 1 exactly while the block is in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | START seen on the bus (strobe) |
| stop_det | input | 1 | STOP seen on the bus (strobe) |
| byte_done | input | 1 | Byte plus acknowledge clock finished (strobe) |
| arb_lost | input | 1 | Arbitration loss seen (strobe) |
| addr_hit | input | 1 | Own slave address matched (strobe) |
| gcall_hit | input | 1 | General call address seen (strobe) |
| rx_bit | input | 1 | Last received bit, valid with byte_done |
| mode_wr | input | 1 | CPU writes the mode bits (strobe) |
| mode_mst | input | 1 | Master bit value for mode_wr |
| mode_tx | input | 1 | Transmit bit value for mode_wr |
| start_req | input | 1 | CPU requests a START (strobe) |
| data_wr | input | 1 | CPU writes the data register (strobe) |
| irq_ack | input | 1 | CPU writes 1 to the pending flag (strobe) |
| status | output | 8 | Status byte, layout per R1 |
| irq_n | output | 1 | Active-low interrupt request |
| gen_start | output | 1 | Enable for the START generator (pulse) |
| cnt_rst | output | 1 | Bit counter reset enable (pulse) |
| scl_drive | output | 1 | SCL drive enable |

## Verification
Every result of this block lands exactly one clock after the edge that samples its cause: the mode bits, all status flags, irq_n and the START and counter-reset pulses. None takes longer. The bench drives strobes at the falling edge and compares all outputs at the next falling edge against a bench-side model advanced by the same rules. Pulse outputs are therefore seen high for one sample and low at the following one. A sweep over every role, busy state and coincident START confirms when a request fires and when it is suppressed.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;
  localparam int STATUS_W = 8;
  localparam int B_MST  = 7;
  localparam int B_TRX  = 6;
  localparam int B_BUSY = 5;
  localparam int B_PEND = 4;
  localparam int B_LRB  = 3;
  localparam int B_GC   = 2;
  localparam int B_AAS  = 1;
  localparam int B_AL   = 0;

  typedef enum logic [1:0] {
    ROLE_SRX = 2'b00,
    ROLE_STX = 2'b01,
    ROLE_MRX = 2'b10,
    ROLE_MTX = 2'b11
  } role_e;

  typedef struct packed {
    logic busy;
    logic pend_n;
    logic lrb;
    logic gc;
    logic aas;
    logic al;
  } flags_t;
endpackage

// File: rtl/i2c_role_start_guard.sv
module i2c_role_start_guard (
  input  logic start_req,
  input  logic mst,
  input  logic busy,
  input  logic start_det,
  output logic fire,
  output logic blocked
);
  logic want;
  always_comb begin
    want    = start_req & mst;
    blocked = want & (busy | start_det);
    fire    = want & ~(busy | start_det);
  end
endmodule

// File: rtl/i2c_role_mode.sv
module i2c_role_mode (
  input  logic clk,
  input  logic rst,
  input  logic stop_det,
  input  logic byte_done,
  input  logic arb_lost,
  input  logic al_flag,
  input  logic blocked,
  input  logic fire,
  input  logic mode_wr,
  input  logic mode_mst,
  input  logic mode_tx,
  output logic mst_q,
  output logic trx_q,
  output logic gen_start_q,
  output logic cnt_rst_q,
  output logic scl_q
);
  logic drop, mst_d, trx_d;

  always_comb begin
    drop  = stop_det | blocked | (byte_done & (al_flag | arb_lost));
    mst_d = mst_q;
    trx_d = trx_q;
    if (drop) begin
      mst_d = 1'b0;
      trx_d = 1'b0;
    end else if (mode_wr) begin
      mst_d = mode_mst;
      trx_d = mode_tx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_q       <= 1'b0;
      trx_q       <= 1'b0;
      gen_start_q <= 1'b0;
      cnt_rst_q   <= 1'b0;
      scl_q       <= 1'b0;
    end else begin
      mst_q       <= mst_d;
      trx_q       <= trx_d;
      gen_start_q <= fire;
      cnt_rst_q   <= fire;
      scl_q       <= mst_d;
    end
  end
endmodule

// File: rtl/i2c_role_flags.sv
module i2c_role_flags
  import i2c_role_pkg::*;
#(
  parameter bit GCALL_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_det,
  input  logic   stop_det,
  input  logic   byte_done,
  input  logic   arb_lost,
  input  logic   addr_hit,
  input  logic   gcall_hit,
  input  logic   rx_bit,
  input  logic   data_wr,
  input  logic   irq_ack,
  output flags_t flags_q
);
  logic bound;
  assign bound = start_det | stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q.busy   <= 1'b0;
      flags_q.pend_n <= 1'b1;
      flags_q.lrb    <= 1'b0;
      flags_q.aas    <= 1'b0;
      flags_q.al     <= 1'b0;
    end else begin
      if (start_det)                flags_q.busy <= 1'b1;
      else if (stop_det)            flags_q.busy <= 1'b0;
      if (byte_done)                flags_q.pend_n <= 1'b0;
      else if (data_wr | irq_ack)   flags_q.pend_n <= 1'b1;
      if (byte_done)                flags_q.lrb <= rx_bit;
      if (addr_hit)                 flags_q.aas <= 1'b1;
      else if (bound)               flags_q.aas <= 1'b0;
      if (arb_lost)                 flags_q.al <= 1'b1;
      else if (start_det)           flags_q.al <= 1'b0;
    end
  end

  generate
    if (GCALL_EN) begin : g_gc
      always_ff @(posedge clk) begin
        if (rst)            flags_q.gc <= 1'b0;
        else if (gcall_hit) flags_q.gc <= 1'b1;
        else if (bound)     flags_q.gc <= 1'b0;
      end
    end else begin : g_nogc
      always_ff @(posedge clk) flags_q.gc <= 1'b0;
      logic unused_gc;
      assign unused_gc = gcall_hit;
    end
  endgenerate
endmodule

// File: rtl/i2c_role_tracker.sv
module i2c_role_tracker
  import i2c_role_pkg::*;
#(
  parameter bit GCALL_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                byte_done,
  input  logic                arb_lost,
  input  logic                addr_hit,
  input  logic                gcall_hit,
  input  logic                rx_bit,
  input  logic                mode_wr,
  input  logic                mode_mst,
  input  logic                mode_tx,
  input  logic                start_req,
  input  logic                data_wr,
  input  logic                irq_ack,
  output logic [STATUS_W-1:0] status,
  output logic                irq_n,
  output logic                gen_start,
  output logic                cnt_rst,
  output logic                scl_drive
);
  logic   mst_q, trx_q, fire, blocked;
  flags_t fl;
  role_e  role;

  i2c_role_start_guard u_guard (
    .start_req(start_req), .mst(mst_q), .busy(fl.busy),
    .start_det(start_det), .fire(fire), .blocked(blocked)
  );

  i2c_role_mode u_mode (
    .clk(clk), .rst(rst), .stop_det(stop_det), .byte_done(byte_done),
    .arb_lost(arb_lost), .al_flag(fl.al), .blocked(blocked), .fire(fire),
    .mode_wr(mode_wr), .mode_mst(mode_mst), .mode_tx(mode_tx),
    .mst_q(mst_q), .trx_q(trx_q), .gen_start_q(gen_start),
    .cnt_rst_q(cnt_rst), .scl_q(scl_drive)
  );

  i2c_role_flags #(.GCALL_EN(GCALL_EN)) u_flags (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .arb_lost(arb_lost), .addr_hit(addr_hit),
    .gcall_hit(gcall_hit), .rx_bit(rx_bit), .data_wr(data_wr),
    .irq_ack(irq_ack), .flags_q(fl)
  );

  assign role = role_e'({mst_q, trx_q});

  always_comb begin
    status         = '0;
    status[B_MST:B_TRX] = role;
    status[B_BUSY] = fl.busy;
    status[B_PEND] = fl.pend_n;
    status[B_LRB]  = fl.lrb;
    status[B_GC]   = fl.gc;
    status[B_AAS]  = fl.aas;
    status[B_AL]   = fl.al;
  end

  assign irq_n = fl.pend_n;
endmodule

// File: rtl/i2c_role_tracker_chk.sv
module i2c_role_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_det,
  input logic       stop_det,
  input logic       byte_done,
  input logic       arb_lost,
  input logic       rx_bit,
  input logic       start_req,
  input logic [7:0] status,
  input logic       irq_n,
  input logic       gen_start,
  input logic       cnt_rst,
  input logic       scl_drive
);
  assert_stop_drops_R3: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (status[7:6] == 2'b00));

  assert_arb_byte_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_done && (arb_lost || status[0])) |=> !status[7]);

  assert_start_fires_R5: assert property (@(posedge clk) disable iff (rst)
    (start_req && status[7] && !status[5] && !start_det && !stop_det)
      |=> (gen_start && cnt_rst));

  assert_start_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (start_req && status[7] && (status[5] || start_det))
      |=> (!gen_start && !cnt_rst && !status[7]));

  assert_slave_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (!status[7]) |=> !gen_start);

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> status[5]);

  assert_pend_drop_R9: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !irq_n);

  assert_lrb_capture_R10: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (status[3] == $past(rx_bit)));

  assert_scl_master_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !scl_drive);
endmodule

bind i2c_role_tracker i2c_role_tracker_chk u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
  .byte_done(byte_done), .arb_lost(arb_lost), .rx_bit(rx_bit),
  .start_req(start_req), .status(status), .irq_n(irq_n),
  .gen_start(gen_start), .cnt_rst(cnt_rst), .scl_drive(scl_drive)
);

// File: tb/sim_i2c_role_tracker.sv
module sim_i2c_role_tracker;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_det = 0, stop_det = 0, byte_done = 0, arb_lost = 0;
  logic addr_hit = 0, gcall_hit = 0, rx_bit = 0;
  logic mode_wr = 0, mode_mst = 0, mode_tx = 0, start_req = 0;
  logic data_wr = 0, irq_ack = 0;
  logic [7:0] status;
  logic irq_n, gen_start, cnt_rst, scl_drive;

  int total = 0;
  int bad = 0;

  logic e_mst, e_trx, e_busy, e_pend, e_lrb, e_gc, e_aas, e_al, e_gs;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  i2c_role_tracker u0 (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .arb_lost(arb_lost), .addr_hit(addr_hit),
    .gcall_hit(gcall_hit), .rx_bit(rx_bit), .mode_wr(mode_wr),
    .mode_mst(mode_mst), .mode_tx(mode_tx), .start_req(start_req),
    .data_wr(data_wr), .irq_ack(irq_ack), .status(status), .irq_n(irq_n),
    .gen_start(gen_start), .cnt_rst(cnt_rst), .scl_drive(scl_drive)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic clear_in();
    {start_det, stop_det, byte_done, arb_lost, addr_hit, gcall_hit, rx_bit} = '0;
    {mode_wr, mode_mst, mode_tx, start_req, data_wr, irq_ack} = '0;
  endtask

  // Advance the model by one edge from the present inputs, then clock and compare.
  task automatic tick();
    logic blk, fire, drop, n_mst, n_trx;
    blk  = start_req & e_mst & (e_busy | start_det);
    fire = start_req & e_mst & ~(e_busy | start_det);
    drop = stop_det | blk | (byte_done & (e_al | arb_lost));
    n_mst = drop ? 1'b0 : (mode_wr ? mode_mst : e_mst);
    n_trx = drop ? 1'b0 : (mode_wr ? mode_tx  : e_trx);
    if (rst) begin
      n_mst = 0; n_trx = 0; fire = 0;
      e_busy = 0; e_pend = 1; e_lrb = 0; e_gc = 0; e_aas = 0; e_al = 0;
    end else begin
      if (byte_done) e_lrb = rx_bit;
      e_pend = byte_done ? 1'b0 : ((data_wr | irq_ack) ? 1'b1 : e_pend);
      e_gc   = gcall_hit ? 1'b1 : ((start_det | stop_det) ? 1'b0 : e_gc);
      e_aas  = addr_hit  ? 1'b1 : ((start_det | stop_det) ? 1'b0 : e_aas);
      e_al   = arb_lost  ? 1'b1 : (start_det ? 1'b0 : e_al);
      e_busy = start_det ? 1'b1 : (stop_det ? 1'b0 : e_busy);
    end
    e_mst = n_mst; e_trx = n_trx; e_gs = fire;
    @(posedge clk);
    @(negedge clk);
    clear_in();
    chk("R2 R3 R4 R6 mode bits", {6'd0, status[7:6]}, {6'd0, e_mst, e_trx});
    chk("R8 busy", {7'd0, status[5]}, {7'd0, e_busy});
    chk("R9 pending", {6'd0, status[4], irq_n}, {6'd0, e_pend, e_pend});
    chk("R10 flags", {4'd0, status[3:0]}, {4'd0, e_lrb, e_gc, e_aas, e_al});
    chk("R5 R7 start pulses", {6'd0, gen_start, cnt_rst}, {6'd0, e_gs, e_gs});
    chk("R11 scl drive", {7'd0, scl_drive}, {7'd0, e_mst});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_in();
    @(negedge clk);
    do_reset();
    chk("R1 reset status", status, 8'h10);
    chk("R1 reset outputs", {5'd0, irq_n, gen_start, scl_drive}, 8'h04);

    // Directed: master transmit, START fires, byte with arb loss drops mode.
    mode_wr = 1; mode_mst = 1; mode_tx = 1; tick();
    chk("R1 R2 master transmit code", {6'd0, status[7:6]}, 8'h03);
    start_req = 1; tick();
    chk("R5 pulse high", {6'd0, gen_start, cnt_rst}, 8'h03);
    start_det = 1; tick();
    chk("R5 pulse one cycle", {7'd0, gen_start}, 8'h00);
    arb_lost = 1; tick();
    chk("R4 arb alone keeps master", {7'd0, status[7]}, 8'h01);
    byte_done = 1; rx_bit = 1; tick();
    chk("R4 byte after arb drops", {6'd0, status[7:6]}, 8'h00);
    chk("R9 irq low after byte", {7'd0, irq_n}, 8'h00);
    byte_done = 1; irq_ack = 1; tick();
    chk("R9 byte_done beats ack", {7'd0, irq_n}, 8'h00);
    data_wr = 1; tick();
    chk("R9 data write releases", {7'd0, irq_n}, 8'h01);
    start_det = 1; stop_det = 1; tick();
    chk("R8 start wins over stop", {7'd0, status[5]}, 8'h01);
    mode_wr = 1; mode_mst = 1; stop_det = 1; tick();
    chk("R2 R3 stop beats mode write", {6'd0, status[7:6]}, 8'h00);

    // Sweep: every role x busy x coincident START, then a START request.
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++) begin
          do_reset();
          if (b == 1) begin start_det = 1; tick(); end
          mode_wr = 1; mode_mst = m[1]; mode_tx = m[0]; tick();
          start_req = 1; start_det = s[0]; tick();
          if (m[1] && (b == 1 || s == 1))
            chk("R6 blocked start", {5'd0, status[7], gen_start, cnt_rst}, 8'h00);
          else if (m[1])
            chk("R5 granted start", {5'd0, status[7], gen_start, cnt_rst}, 8'h07);
          else
            chk("R7 slave ignores start", {5'd0, status[7:6], gen_start}, {5'd0, 1'b0, m[0], 1'b0});
        end

    // Pseudo-random strobe sequences against the model.
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      start_det = (lfsr[3:0] == 4'h1);
      stop_det  = (lfsr[3:0] == 4'h2);
      byte_done = (lfsr[6:4] == 3'h5);
      rx_bit    = lfsr[7];
      arb_lost  = (lfsr[11:8] == 4'h3);
      addr_hit  = (lfsr[11:8] == 4'h7);
      gcall_hit = (lfsr[11:8] == 4'hA);
      mode_wr   = (lfsr[14:12] == 3'h2);
      mode_mst  = lfsr[1];
      mode_tx   = lfsr[9];
      start_req = (lfsr[15:13] == 3'h6);
      data_wr   = (lfsr[5:3] == 3'h0);
      irq_ack   = (lfsr[10:8] == 3'h6);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule